// File: doc/BRIEF.md
# Victim Line Buffer

This block is a tiny, fully associative holding area for cache lines that a direct-mapped primary cache has just thrown out. When the primary cache misses, it presents the missing line address here. In the same cycle it also presents the line it is about to discard. Every valid entry is compared against the address at once. On a match, the stored line goes back to the primary cache, and the discarded primary line takes its slot. A line therefore lives in exactly one of the two structures. When nothing matches, the request is passed on toward memory and the discarded line is stored here. If every slot is occupied, the least recently written entry is overwritten.

The request is registered on the edge where it is presented. The match outcome and the returned line appear in the following cycle. The contents change on the edge after that, which is also the edge that captures the next request. Lines are always clean, because the primary cache writes through, so an overwritten entry is simply dropped.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is empty, and `swap_valid` and `mem_req_valid` are both low.
- R2: Each cycle with `lookup_valid` high produces exactly one result one cycle later: `swap_valid` or `mem_req_valid` is high for that one cycle, never both.
- R3: If the lookup address equals the stored address of a valid entry, `swap_valid` is high and `swap_data` carries that entry's line.
- R4: If no valid entry matches, `mem_req_valid` is high and `mem_req_addr` equals the lookup address.
- R5: On a hit with `evict_valid` high, the evicted line replaces the matched entry. A later lookup of the returned address misses, and a lookup of the evicted address hits with the evicted data.
- R6: On a hit with `evict_valid` low, the matched entry becomes empty. The freed slot is used by the next insertion before any valid line is dropped.
- R7: On a miss with `evict_valid` high, the evicted line is written into an empty slot if there is one, and no stored line is lost.
- R8: On a miss with `evict_valid` high and all slots full, the entry written longest ago is dropped. Every other stored line stays.
- R9: A miss with `evict_valid` low leaves the contents unchanged.
- R10: `evict_valid` in a cycle where `lookup_valid` is low is ignored, and no result is produced for that cycle.
- R11: A lookup presented in the cycle right after another one observes the contents as updated by the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookup_valid | input | 1 | Primary cache missed; look up `lookup_addr` |
| lookup_addr | input | ADDR_W | Line address of the missing line |
| evict_valid | input | 1 | The primary cache is discarding a valid line with this lookup |
| evict_addr | input | ADDR_W | Line address of the discarded line |
| evict_data | input | LINE_W | Contents of the discarded line |
| swap_valid | output | 1 | Lookup hit; `swap_data` goes back to the primary cache |
| swap_data | output | LINE_W | Line returned on a hit |
| mem_req_valid | output | 1 | Lookup missed; fetch the line from memory |
| mem_req_addr | output | ADDR_W | Address to fetch on a miss |

## Verification
Directed sequences test the block against four kinds of pattern. Cold misses show that the result is taken from memory. Hits with and without a line coming back separate a swap from a plain invalidation. Insertions past capacity show which entry the replacement order picks to drop. Back-to-back pairs show that an update is visible to the very next request. A long pseudo-random stream then draws lookups from recently evicted addresses, so hits, misses, frees and drops mix in many orders. Each result is compared with a scoreboard model that keeps the stored lines as a most-recent-first list.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
package vc_pkg;

  typedef enum logic [1:0] {
    VC_IDLE = 2'd0,
    VC_HIT  = 2'd1,
    VC_MISS = 2'd2
  } vc_outcome_e;

  // Position of the (single) set bit of a one-hot vector; zero when empty.
  function automatic int vc_onehot_idx(input logic [63:0] oh);
    int r;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if (oh[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/vc_match.sv
`timescale 1ns/1ps
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/vc_lru.sv
`timescale 1ns/1ps
module vc_lru #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim_idx
);
  // Ages form a permutation of 0..ENTRIES-1; 0 is most recently written.
  logic [ENTRIES-1:0][IDX_W-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx])  age[i] <= age[i] + IDX_W'(1);
      end
    end
  end

  // Lowest empty slot wins; otherwise the oldest valid one.
  always_comb begin
    victim_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (age[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vc_store.sv
`timescale 1ns/1ps
module vc_store #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_valid,
  input  logic [ADDR_W-1:0]              wr_tag,
  input  logic [LINE_W-1:0]              wr_data,
  output logic [ENTRIES-1:0]             valid,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  output logic [ENTRIES-1:0][LINE_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= '0;
    else if (wr_en) valid[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) begin
      tags[wr_idx] <= wr_tag;
      data[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/victim_cache.sv
`timescale 1ns/1ps
module victim_cache #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [LINE_W-1:0] evict_data,
  output logic              swap_valid,
  output logic [LINE_W-1:0] swap_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr
);
  import vc_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Request stage.
  logic              s1_lk;
  logic              s1_ev;
  logic [ADDR_W-1:0] s1_addr;
  logic [ADDR_W-1:0] s1_ev_addr;
  logic [LINE_W-1:0] s1_ev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lk <= 1'b0;
      s1_ev <= 1'b0;
    end else begin
      s1_lk <= lookup_valid;
      s1_ev <= lookup_valid && evict_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr    <= lookup_addr;
    s1_ev_addr <= evict_addr;
    s1_ev_data <= evict_data;
  end

  // Named internal events.
  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tags;
  logic [ENTRIES-1:0][LINE_W-1:0] ent_data;
  logic [ENTRIES-1:0]             hit_vec;
  logic [IDX_W-1:0]               hit_idx;
  logic [IDX_W-1:0]               lru_idx;
  logic [IDX_W-1:0]               fill_idx;
  logic                           lk_hit;
  logic                           lk_miss;
  logic                           fill_en;
  vc_outcome_e                    lk_outcome;

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .valid   (ent_valid),
    .tags    (ent_tags),
    .key     (s1_addr),
    .hit_vec (hit_vec)
  );

  assign hit_idx  = IDX_W'(vc_onehot_idx(64'(hit_vec)));
  assign lk_hit   = s1_lk && (|hit_vec);
  assign lk_miss  = s1_lk && !(|hit_vec);
  assign fill_en  = lk_hit || (lk_miss && s1_ev);
  assign fill_idx = lk_hit ? hit_idx : lru_idx;

  always_comb begin
    if (lk_hit)       lk_outcome = VC_HIT;
    else if (lk_miss) lk_outcome = VC_MISS;
    else              lk_outcome = VC_IDLE;
  end

  vc_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (fill_en && s1_ev),
    .touch_idx  (fill_idx),
    .valid      (ent_valid),
    .victim_idx (lru_idx)
  );

  vc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_valid (s1_ev),
    .wr_tag   (s1_ev_addr),
    .wr_data  (s1_ev_data),
    .valid    (ent_valid),
    .tags     (ent_tags),
    .data     (ent_data)
  );

  assign swap_valid    = (lk_outcome == VC_HIT);
  assign swap_data     = ent_data[hit_idx];
  assign mem_req_valid = (lk_outcome == VC_MISS);
  assign mem_req_addr  = s1_addr;
endmodule

// File: rtl/vc_checker.sv
`timescale 1ns/1ps
module vc_checker #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookup_valid,
  input logic               swap_valid,
  input logic               mem_req_valid,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid,
  input logic               lk_hit,
  input logic               s1_ev
);
  // R2: one result per request, never both kinds.
  a_r2_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_valid && mem_req_valid));

  // R2: a request is answered in the following cycle.
  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> (swap_valid || mem_req_valid));

  // R10: no result without a request one cycle earlier.
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_valid || mem_req_valid) |-> $past(lookup_valid));

  // R3: a line address is stored at most once.
  a_r3_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R5: a swap keeps the occupancy unchanged.
  a_r5_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && s1_ev) |=> ($countones(valid) == $past($countones(valid))));

  // R6: a hit with nothing coming back frees one slot.
  a_r6_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !s1_ev) |=> ($countones(valid) == $past($countones(valid)) - 1));

  // R9: a miss with nothing to insert leaves the contents alone.
  a_r9_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !s1_ev) |=> $stable(valid));
endmodule

bind victim_cache vc_checker #(.ENTRIES(ENTRIES)) u_vc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .lookup_valid  (lookup_valid),
  .swap_valid    (swap_valid),
  .mem_req_valid (mem_req_valid),
  .hit_vec       (hit_vec),
  .valid         (ent_valid),
  .lk_hit        (lk_hit),
  .s1_ev         (s1_ev)
);

// File: tb/tb_victim_cache.sv
`timescale 1ns/1ps
module tb_victim_cache;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 26;
  localparam int LINE_W  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lookup_valid = 1'b0;
  logic [ADDR_W-1:0] lookup_addr = '0;
  logic              evict_valid = 1'b0;
  logic [ADDR_W-1:0] evict_addr = '0;
  logic [LINE_W-1:0] evict_data = '0;
  logic              swap_valid;
  logic [LINE_W-1:0] swap_data;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;

  victim_cache #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .swap_valid(swap_valid), .swap_data(swap_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int                due;
    bit                hit;
    logic [LINE_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference contents, most recently written first.
  logic [ADDR_W-1:0] m_addr[$];
  logic [LINE_W-1:0] m_data[$];

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {8'hC5, 30'(a), 26'(a ^ 26'h2A5A5A5)};
  endfunction

  task automatic send(input bit lk, input logic [ADDR_W-1:0] a,
                      input bit ev, input logic [ADDR_W-1:0] ea, input string tag);
    exp_t e;
    int   pos;
    @(posedge clk); #2;
    lookup_valid = lk;
    lookup_addr  = a;
    evict_valid  = ev;
    evict_addr   = ea;
    evict_data   = line_of(ea);
    if (lk) begin
      pos = -1;
      foreach (m_addr[i]) if (m_addr[i] == a) pos = i;
      e.due  = cyc + 1;
      e.addr = a;
      e.tag  = tag;
      e.hit  = (pos >= 0);
      e.data = (pos >= 0) ? m_data[pos] : '0;
      exp_q.push_back(e);
      if (pos >= 0) begin
        m_addr.delete(pos);
        m_data.delete(pos);
      end
      if (ev) begin
        m_addr.push_front(ea);
        m_data.push_front(line_of(ea));
        if (m_addr.size() > ENTRIES) begin
          void'(m_addr.pop_back());
          void'(m_data.pop_back());
        end
      end
    end
  endtask

  task automatic idle();
    send(1'b0, '0, 1'b0, '0, "idle");
  endtask

  // Monitor: compare results with the scoreboard away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.hit) begin
          if (!(swap_valid && !mem_req_valid && swap_data == e.data)) begin
            fails++;
            $display("FAIL %s addr=%h: swap=%b mem=%b data=%h, expected hit data=%h",
                     e.tag, e.addr, swap_valid, mem_req_valid, swap_data, e.data);
          end
        end else begin
          if (!(mem_req_valid && !swap_valid && mem_req_addr == e.addr)) begin
            fails++;
            $display("FAIL %s addr=%h: swap=%b mem=%b mem_addr=%h, expected miss to %h",
                     e.tag, e.addr, swap_valid, mem_req_valid, mem_req_addr, e.addr);
          end
        end
      end else if (swap_valid || mem_req_valid) begin
        fails++;
        $display("FAIL R2/R10 unrequested result: swap=%b mem=%b, expected 0 0",
                 swap_valid, mem_req_valid);
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int          nxt;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (swap_valid || mem_req_valid) begin
      fails++;
      $display("FAIL R1 outputs in reset: swap=%b mem=%b, expected 0 0", swap_valid, mem_req_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R4: empty after reset, cold miss inserts the evicted line.
    send(1, 26'h100, 1, 26'h200, "R1 R4 cold miss");
    // R3 / R5: hit swaps in a new line.
    send(1, 26'h200, 1, 26'h300, "R3 R5 hit with swap");
    send(1, 26'h200, 0, 26'h0,   "R5 R9 returned line gone");
    // R6: hit with nothing coming back frees the slot.
    send(1, 26'h300, 0, 26'h0,   "R5 R6 swapped line present");
    send(1, 26'h300, 0, 26'h0,   "R6 freed line gone");

    // R7: fill all slots.
    for (int i = 0; i < ENTRIES; i++)
      send(1, 26'h900 + 26'(i), 1, 26'h10 + 26'(i), "R7 fill");
    // R8: overfill drops the oldest line (0x10).
    send(1, 26'h904, 1, 26'h14, "R8 overfill");
    send(1, 26'h10,  0, 26'h0,  "R8 oldest dropped");
    send(1, 26'h11,  1, 26'h15, "R7 R8 others kept");
    send(1, 26'h920, 1, 26'h16, "R8 second overfill");
    send(1, 26'h12,  0, 26'h0,  "R8 oldest dropped again");
    // R6: free a slot, then insert without losing anything.
    send(1, 26'h13,  0, 26'h0,  "R6 hit frees");
    send(1, 26'h921, 1, 26'h17, "R6 R7 insert into freed slot");
    send(1, 26'h14,  0, 26'h0,  "R6 R7 line kept");
    send(1, 26'h15,  0, 26'h0,  "R6 R7 line kept");

    // R10: eviction without lookup is ignored.
    idle();
    send(0, 26'h0,   1, 26'h40, "R10 evict only");
    idle();
    send(1, 26'h40,  0, 26'h0,  "R10 ignored evict absent");

    // R11: back-to-back update visibility.
    send(1, 26'h930, 1, 26'h50, "R11 first");
    send(1, 26'h50,  1, 26'h51, "R11 next sees insert");
    send(1, 26'h51,  0, 26'h0,  "R11 next sees swap");
    idle();

    // Mixed stream: lookups drawn from recently evicted addresses.
    lfsr = 16'hACE1;
    nxt  = 0;
    for (int n = 0; n < 200; n++) begin
      int back;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      back = int'(lfsr[2:0]) + 1;
      send(1, 26'h1000 + 26'(nxt - back), lfsr[5] | lfsr[6], 26'h1000 + 26'(nxt),
           "R3 R4 R5 R6 R8 mixed");
      if (lfsr[5] | lfsr[6]) nxt++;
      if (lfsr[9]) idle();
    end
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing results: %0d pending, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule